// File: doc/BRIEF.md
# ADC Command Decoder and Conversion Sequencer

This block sits between a serial command port and the analog front end of a 10-bit successive-approximation converter. Each 16-bit command word that the serial port delivers is decoded into one of five actions: stop, a single conversion, a digital read of eight port inputs, a do-nothing word, or arming of a trigger-started conversion. The sequencer then selects the analog channel, presents trial codes to the DAC and collects the comparator answers, one bit per clock. The result goes into a 16-bit word for the serial port to shift out.

Completion is signalled on an active-high done output and an active-low interrupt. Both clear when the serial side reports that the word was read, or when a new non-NOP command is accepted. A command that arrives while a conversion runs cancels it, except a NOP, which leaves everything running. A completion that lands while a command word is still being shifted in is held back until that word has ended. Commands that follow the previous accepted one too closely are dropped and raise a sticky error flag.

Top module: `adc_cmd_seq`

## Requirements
- R1: The operation field is cmd_i[15:13]. 001 is a single conversion, 101 arms auto-trigger, 100 is NOP, and 000 is STOP. Every other code (010, 011, 110, 111) behaves exactly like STOP.
- R2: The channel field is cmd_i[12:8]. Codes 0..23 select an analog input, and mux_sel_o carries that code for the whole conversion. Code 31 selects the port read, but only with opcode 001. Codes 24..30, and code 31 with opcode 101, behave like STOP.
- R3: After reset, and on STOP, the converter is idle and auto-trigger is disarmed. In this state done_o=0, irq_no=1, result_o=0, mux_sel_o=0 and dac_code_o=0.
- R4: A conversion is a binary search from MSB to LSB, one bit per clock. A bit is kept when cmp_i=1 (input at or above the trial code). done_o rises on the 11th clock edge after the accepting edge, which is well inside 50 clocks.
- R5: A conversion result word is {code[9:0], 1'b1, channel[4:0]}. While done_o=0, result_o reads 0000h.
- R6: On completion, done_o goes to 1 and irq_no goes to 0. Both return to their idle levels after a one-cycle pulse on read_done_i, or when a non-NOP command is accepted.
- R7: A new accepted non-NOP command cancels a running conversion, and the cancelled conversion reports nothing. An accepted NOP changes nothing: a running conversion finishes with its own result.
- R8: A completion that occurs while rx_active_i=1 does not show on done_o until a clock edge where rx_active_i=0. If the word accepted at that point is not a NOP, the held result is discarded.
- R9: When armed, a rising edge on trig_i starts a conversion on the armed channel. The edge counts only after trig_i has been stable over two consecutive tick_i samples, so a one-clock pulse is ignored. The block stays armed after each conversion and through NOPs. STOP disarms it, and a new channel takes effect only through a new auto-trigger command.
- R10: A port read lasts 10 clocks, with done_o rising on the 11th edge. The result is {port_i[7:0], 2'b00, 1'b1, 5'b11111}.
- R11: A command whose cmd_valid_i edge is fewer than 4 clocks after the previous accepted command is ignored, and err_o is set. err_o stays set until reset. A gap of exactly 4 clocks is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle strobe: a complete command word is on cmd_i |
| cmd_i | input | 16 | Command word |
| rx_active_i | input | 1 | A command word is being shifted in |
| read_done_i | input | 1 | One-cycle strobe: the result word has been shifted out |
| tick_i | input | 1 | Trigger sampling tick (1 us) |
| trig_i | input | 1 | External trigger pin, idle high |
| cmp_i | input | 1 | Comparator: selected input is at or above dac_code_o |
| port_i | input | 8 | Thresholded levels of port inputs 23..16 |
| mux_sel_o | output | 5 | Channel select toward the analog multiplexer |
| dac_code_o | output | 10 | Trial code toward the DAC |
| done_o | output | 1 | Conversion complete, active high |
| irq_no | output | 1 | Interrupt, active low |
| result_o | output | 16 | Result word for the serial port |
| err_o | output | 1 | Sticky flag for commands that came too close together |

## Verification
Some properties are checked on every cycle: the command spacing, the stickiness of err_o, a stable channel select during a conversion, and an immediate stop after STOP. Also checked every cycle: done_o may rise only from a completion or a held completion, never while a word is being received, and no conversion runs longer than the limit. Only the bench scenarios can show that the search converges to the right code on every channel and across a sweep of input levels. The same holds for the exact completion cycle, cancel against NOP, the held completion released by a NOP or discarded by a new command, the trigger glitch filter and re-arming, and the layout of the port-read word.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {K_STOP, K_CONV, K_PORT, K_NOP, K_AUTO} kind_e;

  localparam logic [2:0] OP_ONCE = 3'b001;
  localparam logic [2:0] OP_NOP  = 3'b100;
  localparam logic [2:0] OP_AUTO = 3'b101;

  function automatic kind_e decode_cmd(input logic [2:0] op, input logic [4:0] ch,
                                       input int unsigned nch);
    kind_e k;
    k = K_STOP;
    case (op)
      OP_ONCE: begin
        if (32'(ch) < nch) k = K_CONV;
        else if (ch == 5'h1f) k = K_PORT;
      end
      OP_AUTO: if (32'(ch) < nch) k = K_AUTO;
      OP_NOP:  k = K_NOP;
      default: k = K_STOP;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/adc_cmd_dec.sv
module adc_cmd_dec
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 24,
  parameter int unsigned MIN_GAP = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [15:0] word_i,
  output logic        acc_o,
  output kind_e       kind_o,
  output logic [4:0]  ch_o,
  output logic        err_o
);
  localparam int unsigned GAP_W = $clog2(MIN_GAP + 1);

  logic [GAP_W-1:0] gap_q;
  logic             gap_ok;
  logic             err_q;
  logic             unused_low;

  assign unused_low = ^word_i[7:0];
  assign gap_ok = (gap_q >= GAP_W'(MIN_GAP));
  assign acc_o  = valid_i && gap_ok;
  assign ch_o   = word_i[12:8];
  assign kind_o = decode_cmd(word_i[15:13], word_i[12:8], NUM_CH);
  assign err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_W'(MIN_GAP);
      err_q <= 1'b0;
    end else begin
      if (acc_o) gap_q <= GAP_W'(1);
      else if (!gap_ok) gap_q <= gap_q + GAP_W'(1);
      if (valid_i && !gap_ok) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_trig_filt.sv
module adc_trig_filt #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  output logic rise_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              smp_q, filt_q, filt_d, rise_q;
  logic              s_in;

  assign s_in   = sync_q[SYNC_N-1];
  assign filt_d = (tick_i && (s_in == smp_q)) ? smp_q : filt_q;
  assign rise_o = rise_q;

  // pin idles high: all stages reset to 1 so reset never looks like an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      smp_q  <= 1'b1;
      filt_q <= 1'b1;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], trig_i};
      if (tick_i) smp_q <= s_in;
      filt_q <= filt_d;
      rise_q <= filt_d && !filt_q;
    end
  end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned PORT_CYC = 10,
  parameter int unsigned CH_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              port_mode_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              abort_i,
  input  logic              cmp_i,
  input  logic [PORT_W-1:0] port_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] code_o,
  output logic [PORT_W-1:0] port_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              port_sel_o,
  output logic [DATA_W-1:0] dac_o,
  output logic [CH_W-1:0]   sel_o
);
  localparam int unsigned CNT_MAX = (PORT_CYC > DATA_W) ? PORT_CYC : DATA_W;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX);

  logic              busy_q, pm_q, done_q;
  logic [CNT_W-1:0]  idx_q;
  logic [DATA_W-1:0] acc_q, trial, acc_n, code_q;
  logic [PORT_W-1:0] port_q;
  logic [CH_W-1:0]   ch_q;

  assign trial = DATA_W'(1) << idx_q;
  assign acc_n = cmp_i ? (acc_q | trial) : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pm_q   <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      code_q <= '0;
      port_q <= '0;
      ch_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        pm_q   <= port_mode_i;
        ch_q   <= ch_i;
        acc_q  <= '0;
        idx_q  <= port_mode_i ? CNT_W'(PORT_CYC - 1) : CNT_W'(DATA_W - 1);
      end else if (abort_i) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (!pm_q) acc_q <= acc_n;
        if (idx_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (pm_q) port_q <= port_i;
          else      code_q <= acc_n;
        end else begin
          idx_q <= idx_q - CNT_W'(1);
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign code_o     = code_q;
  assign port_o     = port_q;
  assign ch_o       = ch_q;
  assign port_sel_o = pm_q;
  assign dac_o      = (busy_q && !pm_q) ? (acc_q | trial) : '0;
  assign sel_o      = busy_q ? ch_q : '0;
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned NUM_CH   = 24,
  parameter int unsigned PORT_CYC = 10,
  parameter int unsigned MIN_GAP  = 4,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [15:0]       cmd_i,
  input  logic              rx_active_i,
  input  logic              read_done_i,
  input  logic              tick_i,
  input  logic              trig_i,
  input  logic              cmp_i,
  input  logic [PORT_W-1:0] port_i,
  output logic [4:0]        mux_sel_o,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              done_o,
  output logic              irq_no,
  output logic [DATA_W+5:0] result_o,
  output logic              err_o
);
  localparam int unsigned CH_W  = 5;
  localparam int unsigned RES_W = DATA_W + 1 + CH_W;
  localparam int unsigned PAD_W = RES_W - PORT_W - 1 - CH_W;

  logic              acc_w, cancel_w;
  kind_e             kind_w;
  logic [CH_W-1:0]   dch_w;
  logic              eng_start, eng_port, eng_abort, eng_busy, eng_done;
  logic [CH_W-1:0]   eng_ch, rch_w;
  logic [DATA_W-1:0] code_w;
  logic [PORT_W-1:0] portv_w;
  logic              rport_w, trig_rise;
  logic              armed_q, done_q, pend_q;
  logic [CH_W-1:0]   arm_ch_q;
  logic [RES_W-1:0]  res_q, res_new;

  adc_cmd_dec #(.NUM_CH(NUM_CH), .MIN_GAP(MIN_GAP)) u_dec (
    .clk_i, .rst_ni, .valid_i(cmd_valid_i), .word_i(cmd_i),
    .acc_o(acc_w), .kind_o(kind_w), .ch_o(dch_w), .err_o
  );

  adc_trig_filt #(.SYNC_N(SYNC_N)) u_trig (
    .clk_i, .rst_ni, .tick_i, .trig_i, .rise_o(trig_rise)
  );

  adc_sar_core #(.DATA_W(DATA_W), .PORT_W(PORT_W), .PORT_CYC(PORT_CYC), .CH_W(CH_W)) u_sar (
    .clk_i, .rst_ni, .start_i(eng_start), .port_mode_i(eng_port), .ch_i(eng_ch),
    .abort_i(eng_abort), .cmp_i, .port_i, .busy_o(eng_busy), .done_o(eng_done),
    .code_o(code_w), .port_o(portv_w), .ch_o(rch_w), .port_sel_o(rport_w),
    .dac_o(dac_code_o), .sel_o(mux_sel_o)
  );

  assign cancel_w = acc_w && (kind_w != K_NOP);

  always_comb begin
    eng_start = 1'b0;
    eng_port  = 1'b0;
    eng_abort = 1'b0;
    eng_ch    = dch_w;
    if (acc_w) begin
      case (kind_w)
        K_CONV: eng_start = 1'b1;
        K_PORT: begin eng_start = 1'b1; eng_port = 1'b1; eng_ch = '1; end
        K_STOP, K_AUTO: eng_abort = 1'b1;
        default: ;
      endcase
    end else if (armed_q && trig_rise && !eng_busy) begin
      eng_start = 1'b1;
      eng_ch    = arm_ch_q;
    end
  end

  assign res_new = rport_w ? {portv_w, {PAD_W{1'b0}}, 1'b1, {CH_W{1'b1}}}
                           : {code_w, 1'b1, rch_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      arm_ch_q <= '0;
      done_q   <= 1'b0;
      pend_q   <= 1'b0;
      res_q    <= '0;
    end else if (cancel_w) begin
      armed_q <= (kind_w == K_AUTO);
      if (kind_w == K_AUTO) arm_ch_q <= dch_w;
      done_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else if (eng_done) begin
      res_q <= res_new;
      if (rx_active_i) pend_q <= 1'b1;
      else             done_q <= 1'b1;
    end else if (pend_q && !rx_active_i) begin
      done_q <= 1'b1;
      pend_q <= 1'b0;
    end else if (read_done_i) begin
      done_q <= 1'b0;
    end
  end

  assign done_o   = done_q;
  assign irq_no   = !done_q;
  assign result_o = done_q ? res_q : '0;
endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int unsigned MAX_CONV = 50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_w,
  input kind_e      kind_w,
  input logic [4:0] cmd_ch,
  input logic       eng_busy,
  input logic       eng_start,
  input logic       eng_done,
  input logic       pend_q,
  input logic       done_o,
  input logic       rx_active_i,
  input logic       err_o,
  input logic [4:0] mux_sel_o
);
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (eng_start) run_q <= '0;
    else if (eng_busy && run_q != 8'hff) run_q <= run_q + 8'd1;
    else if (!eng_busy) run_q <= '0;
  end

  p_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(run_q) <= MAX_CONV);

  p_stop_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_w && kind_w == K_STOP) |=> (!eng_busy && !done_o));

  p_conv_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_w && kind_w == K_CONV) |=> (eng_busy && mux_sel_o == $past(cmd_ch)));

  p_sel_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_busy && $past(eng_busy) && !$past(eng_start)) |-> $stable(mux_sel_o));

  p_done_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(eng_done || pend_q));

  p_defer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(rx_active_i));

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_gap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_w |=> !acc_w);
endmodule

bind adc_cmd_seq adc_cmd_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_w(acc_w), .kind_w(kind_w), .cmd_ch(cmd_i[12:8]),
  .eng_busy(eng_busy), .eng_start(eng_start), .eng_done(eng_done), .pend_q(pend_q),
  .done_o(done_o), .rx_active_i(rx_active_i), .err_o(err_o), .mux_sel_o(mux_sel_o)
);

// File: tb/sim_adc_cmd_seq.sv
module sim_adc_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd = '0;
  logic        rx_active = 1'b0;
  logic        read_done = 1'b0;
  logic        tick = 1'b0;
  logic        trig = 1'b1;
  logic        cmp;
  logic [7:0]  port = '0;
  logic [4:0]  sel;
  logic [9:0]  dac;
  logic        done, irq_n, err;
  logic [15:0] result;
  logic [9:0]  vin [24];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (sel < 5'd24) ? (vin[sel] >= dac) : 1'b0;

  adc_cmd_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .rx_active_i(rx_active), .read_done_i(read_done), .tick_i(tick), .trig_i(trig),
    .cmp_i(cmp), .port_i(port), .mux_sel_o(sel), .dac_code_o(dac), .done_o(done),
    .irq_no(irq_n), .result_o(result), .err_o(err)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == TICK_DIV - 1);
      tc = (tc == TICK_DIV - 1) ? 0 : tc + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_raw(input logic [15:0] w);
    cmd_valid = 1'b1;
    cmd = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [15:0] w);
    send_raw(w);
    cyc(4);
  endtask

  task automatic do_read();
    read_done = 1'b1;
    @(negedge clk);
    read_done = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b0;
    cyc(16);
    trig = 1'b1;
  endtask

  task automatic wait_done(input int maxc, output int n);
    n = 0;
    while (!done && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [15:0] mk(input logic [2:0] op, input logic [4:0] ch);
    return {op, ch, 8'h00};
  endfunction

  function automatic logic [15:0] conv_word(input logic [9:0] c, input logic [4:0] ch);
    return {c, 1'b1, ch};
  endfunction

  task automatic conv_check(input logic [4:0] ch, input string req);
    send_raw(mk(3'b001, ch));
    cyc(5);
    chk({req, " R2 mux"}, 32'(sel), 32'(ch));
    cyc(5);
    chk({req, " R4 early"}, 32'(done), 0);
    cyc(1);
    chk({req, " R6 done"}, 32'(done), 1);
    chk({req, " R6 irq"}, 32'(irq_n), 0);
    chk({req, " R5 word"}, 32'(result), 32'(conv_word(vin[ch], ch)));
    do_read();
    chk({req, " R6 cleared"}, 32'({done, irq_n}), 32'(2'b01));
    chk({req, " R5 zero"}, 32'(result), 0);
    cyc(2);
  endtask

  initial begin
    int n;
    for (int i = 0; i < 24; i++) vin[i] = 10'((i * 173 + 29) % 1024);
    cyc(3);
    chk("R3 reset done", 32'(done), 0);
    chk("R3 reset irq", 32'(irq_n), 1);
    chk("R3 reset result", 32'(result), 0);
    chk("R3 reset mux/dac", 32'({sel, dac}), 0);
    chk("R11 reset err", 32'(err), 0);
    rst_n = 1'b1;
    cyc(2);

    // every channel once
    for (int ch = 0; ch < 24; ch++) conv_check(5'(ch), "chan sweep");

    // level sweep on one channel, including both rails
    for (int k = 0; k < 42; k++) begin
      vin[7] = (k == 0) ? 10'd0 : (k == 1) ? 10'd1023 : 10'((k * 251 + 7) % 1024);
      conv_check(5'd7, "R4 level sweep");
    end

    // R7: cancel by a new single conversion
    send_raw(mk(3'b001, 5'd1));
    cyc(4);
    send_raw(mk(3'b001, 5'd2));
    cyc(10);
    chk("R7 cancel early", 32'(done), 0);
    cyc(1);
    chk("R7 cancel result", 32'(result), 32'(conv_word(vin[2], 5'd2)));
    do_read();
    cyc(3);

    // R7: NOP leaves the running conversion alone
    send_raw(mk(3'b001, 5'd3));
    cyc(4);
    send_raw(mk(3'b100, 5'd9));
    cyc(6);
    chk("R7 nop keeps conv", 32'(result), 32'(conv_word(vin[3], 5'd3)));
    do_read();
    send(mk(3'b100, 5'd0));
    cyc(15);
    chk("R7 nop idle", 32'(done), 0);

    // R3/R1: STOP and every illegal opcode cancel a conversion
    for (int op = 0; op < 8; op++) begin
      if (op == 1 || op == 4 || op == 5) continue;
      send_raw(mk(3'b001, 5'd4));
      cyc(4);
      send_raw(mk(3'(op), 5'd4));
      cyc(1);
      chk("R1 R3 stop idles mux", 32'(sel), 0);
      cyc(20);
      chk("R1 R3 stop no done", 32'(done), 0);
    end

    // R2: out-of-range channels behave as STOP
    for (int c = 24; c < 31; c++) begin
      send(mk(3'b001, 5'(c)));
      cyc(16);
      chk("R2 bad channel", 32'(done), 0);
    end

    // R10: port read
    for (int k = 0; k < 8; k++) begin
      port = 8'((k * 37 + 5) & 8'hff);
      send_raw(mk(3'b001, 5'd31));
      cyc(10);
      chk("R10 port early", 32'(done), 0);
      cyc(1);
      chk("R10 port word", 32'(result), 32'({port, 2'b00, 1'b1, 5'b11111}));
      do_read();
      cyc(2);
    end

    // R8: completion held while a word is received, released by NOP
    send_raw(mk(3'b001, 5'd6));
    cyc(3);
    rx_active = 1'b1;
    cyc(15);
    chk("R8 held", 32'(done), 0);
    rx_active = 1'b0;
    send_raw(mk(3'b100, 5'd0));
    chk("R8 released", 32'(result), 32'(conv_word(vin[6], 5'd6)));
    do_read();
    cyc(3);
    // R8: held completion dropped by a new command
    send_raw(mk(3'b001, 5'd8));
    cyc(3);
    rx_active = 1'b1;
    cyc(15);
    rx_active = 1'b0;
    send_raw(mk(3'b001, 5'd9));
    chk("R8 dropped", 32'(done), 0);
    cyc(10);
    chk("R8 new early", 32'(done), 0);
    cyc(1);
    chk("R8 new result", 32'(result), 32'(conv_word(vin[9], 5'd9)));
    do_read();
    cyc(3);

    // R9: auto-trigger
    send(mk(3'b101, 5'd5));
    trig = 1'b0;
    cyc(30);
    chk("R9 falling no start", 32'(done), 0);
    trig = 1'b1;
    wait_done(80, n);
    chk("R9 first result", 32'(result), 32'(conv_word(vin[5], 5'd5)));
    do_read();
    cyc(20);
    pulse_trig();
    wait_done(80, n);
    chk("R9 rearmed", 32'(result), 32'(conv_word(vin[5], 5'd5)));
    do_read();
    send(mk(3'b100, 5'd12));
    cyc(20);
    pulse_trig();
    wait_done(80, n);
    chk("R9 armed after nop", 32'(result), 32'(conv_word(vin[5], 5'd5)));
    do_read();
    cyc(20);
    trig = 1'b0;
    cyc(1);
    trig = 1'b1;
    cyc(60);
    chk("R9 glitch filtered", 32'(done), 0);
    send(mk(3'b000, 5'd0));
    pulse_trig();
    cyc(60);
    chk("R9 stop disarms", 32'(done), 0);
    send(mk(3'b101, 5'd31));
    pulse_trig();
    cyc(60);
    chk("R2 auto with port code", 32'(done), 0);
    send(mk(3'b101, 5'd10));
    pulse_trig();
    wait_done(80, n);
    chk("R9 new channel", 32'(result), 32'(conv_word(vin[10], 5'd10)));
    do_read();
    send(mk(3'b000, 5'd0));
    cyc(10);

    // R11: gap of 4 accepted, gap of 3 rejected
    chk("R11 no err yet", 32'(err), 0);
    send_raw(mk(3'b001, 5'd12));
    cyc(3);
    send_raw(mk(3'b000, 5'd0));
    cyc(15);
    chk("R11 gap4 accepted", 32'(done), 0);
    chk("R11 gap4 no err", 32'(err), 0);
    send_raw(mk(3'b001, 5'd11));
    cyc(2);
    send_raw(mk(3'b000, 5'd0));
    chk("R11 err set", 32'(err), 1);
    cyc(8);
    chk("R11 ignored stop", 32'(result), 32'(conv_word(vin[11], 5'd11)));
    do_read();
    cyc(10);
    chk("R11 err sticky", 32'(err), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule